// File: doc/BRIEF.md
# Incremented-Operand Magnitude Comparator

This block compares an unsigned operand A with the successor of a second unsigned operand B, that is with B+1. It raises five relation flags: greater, greater-or-equal, less, less-or-equal and equal. The increment is formed one bit wider than the operands, and its carry out serves as an overflow flag. When B holds the all-ones value, B+1 does not fit in the operand width. In that case the overflow flag is raised and every relation flag is held low, whatever the value of A.

The block is purely combinational. It has no clock, no reset and no storage, so it can be placed inside any pipeline stage that needs a "compare against next value" decision. The operand width is a parameter that defaults to 4 bits. A second parameter selects how the magnitude compare is built. Variant 0 uses a direct relational compare. Variant 1 uses a bit-serial chain that scans from the most significant bit down. Both variants must give the same outputs.

Top module: `succ_cmp`

## Requirements
- R1: `inc_ovf` is 1 exactly when `b_val` is all ones (15 at the default width of 4), and 0 for every other value of `b_val`.
- R2: While `inc_ovf` is 1, all five relation outputs (`a_gt`, `a_ge`, `a_lt`, `a_le`, `a_eq`) are 0 for every value of `a_val`.
- R3: While `inc_ovf` is 0, `a_eq` is 1 exactly when `a_val` equals `b_val`+1.
- R4: While `inc_ovf` is 0, `a_gt` is 1 exactly when `a_val` is greater than `b_val`+1.
- R5: While `inc_ovf` is 0, `a_lt` is 1 exactly when `a_val` is less than `b_val`+1.
- R6: While `inc_ovf` is 0, `a_ge` equals `a_gt` OR `a_eq`, and `a_le` equals `a_lt` OR `a_eq`.
- R7: While `inc_ovf` is 0, exactly one of `a_gt`, `a_eq` and `a_lt` is 1.
- R8: With `a_val`=9 and `b_val`=5, `a_gt` and `a_ge` are 1, and `a_lt`, `a_le`, `a_eq` and `inc_ovf` are 0.
- R9: `CMP_ARCH`=0 (direct compare) and `CMP_ARCH`=1 (MSB-first bit chain) give identical outputs for every input pair.
- R10: The outputs are a pure function of the present inputs. A new input pair is reflected on the outputs in the same time step, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_val | input | WIDTH | Operand A, unsigned |
| b_val | input | WIDTH | Operand B, unsigned; compared as B+1 |
| a_gt | output | 1 | A > B+1 |
| a_ge | output | 1 | A >= B+1 |
| a_lt | output | 1 | A < B+1 |
| a_le | output | 1 | A <= B+1 |
| a_eq | output | 1 | A = B+1 |
| inc_ovf | output | 1 | B+1 does not fit in WIDTH bits |

## Verification
The bench drives all 256 operand pairs into both compare variants. This includes the sixteen pairs with B at 15, where a design that ignored the carry would compare A against a wrapped value of 0 and report A greater or equal. The pairs where A equals B or B+2 sit on either side of the equal point. They expose an off-by-one in the increment, which would move the equal flag onto the wrong A. The case A=15, B=14 tests the top of the range without overflow, where a carry detector that fired one value early would wrongly clear the flags. Comparing the two variants pair by pair catches a chain that loses its "already decided" state part way down the bits.

// File: rtl/succ_cmp_pkg.sv
package succ_cmp_pkg;

   // outcome of a three-way magnitude compare
   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } rel3_t;

   // compare structure selectors
   localparam int ARCH_DIRECT = 0;
   localparam int ARCH_CHAIN  = 1;

   localparam int MAX_WIDTH = 32;

endpackage

// File: rtl/succ_cmp_inc.sv
module succ_cmp_inc #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] opnd,
   output logic [WIDTH-1:0] succ,
   output logic             carry
);
   localparam int XW = WIDTH + 1;

   logic [XW-1:0] wide_sum;

   // one bit wider than the operand so the carry falls out directly
   assign wide_sum = {1'b0, opnd} + XW'(1);
   assign succ     = wide_sum[WIDTH-1:0];
   assign carry    = wide_sum[WIDTH];

endmodule

// File: rtl/succ_cmp_mag.sv
module succ_cmp_mag
   import succ_cmp_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int CMP_ARCH = ARCH_DIRECT
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   output rel3_t            rel
);

   generate
      if (CMP_ARCH == ARCH_DIRECT) begin : g_direct
         assign rel.gt = (lhs > rhs);
         assign rel.lt = (lhs < rhs);
         assign rel.eq = (lhs == rhs);
      end else begin : g_chain
         // decided-greater / decided-less travel from MSB toward LSB
         logic [WIDTH:0] gt_c;
         logic [WIDTH:0] lt_c;
         assign gt_c[WIDTH] = 1'b0;
         assign lt_c[WIDTH] = 1'b0;
         for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_bit
            assign gt_c[i] = gt_c[i+1] | (~lt_c[i+1] &  lhs[i] & ~rhs[i]);
            assign lt_c[i] = lt_c[i+1] | (~gt_c[i+1] & ~lhs[i] &  rhs[i]);
         end
         assign rel.gt = gt_c[0];
         assign rel.lt = lt_c[0];
         assign rel.eq = ~gt_c[0] & ~lt_c[0];
      end
   endgenerate

endmodule

// File: rtl/succ_cmp_flags.sv
module succ_cmp_flags
   import succ_cmp_pkg::*;
(
   input  rel3_t rel,
   input  logic  ovf,
   output logic  f_gt,
   output logic  f_ge,
   output logic  f_lt,
   output logic  f_le,
   output logic  f_eq
);
   logic live;

   assign live = ~ovf;

   // ge/le come from the opposite strict flag, not from an OR
   assign f_gt = live & rel.gt;
   assign f_lt = live & rel.lt;
   assign f_eq = live & rel.eq;
   assign f_ge = live & ~rel.lt;
   assign f_le = live & ~rel.gt;

   always_comb begin
      // R7: the raw three-way outcome is one-hot
      a_r7_one_hot: assert ($onehot({rel.gt, rel.eq, rel.lt}))
         else $error("three-way compare not one-hot");
      // R6: inclusive flags agree with strict flags
      if (!ovf) begin
         a_r6_ge_split: assert (f_ge == (f_gt | f_eq))
            else $error("ge flag disagrees with gt|eq");
         a_r6_le_split: assert (f_le == (f_lt | f_eq))
            else $error("le flag disagrees with lt|eq");
      end
   end

endmodule

// File: rtl/succ_cmp.sv
module succ_cmp
   import succ_cmp_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int CMP_ARCH = ARCH_DIRECT
) (
   input  logic [WIDTH-1:0] a_val,
   input  logic [WIDTH-1:0] b_val,
   output logic             a_gt,
   output logic             a_ge,
   output logic             a_lt,
   output logic             a_le,
   output logic             a_eq,
   output logic             inc_ovf
);
   localparam logic [WIDTH-1:0] ALL_ONES = '1;

   generate
      if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("succ_cmp: WIDTH out of range");
      end
      if (CMP_ARCH != ARCH_DIRECT && CMP_ARCH != ARCH_CHAIN) begin : g_bad_arch
         $error("succ_cmp: unknown CMP_ARCH");
      end
   endgenerate

   logic [WIDTH-1:0] b_succ;
   logic             b_carry;
   rel3_t            rel;

   succ_cmp_inc #(.WIDTH(WIDTH)) u_inc (
      .opnd  (b_val),
      .succ  (b_succ),
      .carry (b_carry)
   );

   succ_cmp_mag #(.WIDTH(WIDTH), .CMP_ARCH(CMP_ARCH)) u_mag (
      .lhs (a_val),
      .rhs (b_succ),
      .rel (rel)
   );

   succ_cmp_flags u_flags (
      .rel  (rel),
      .ovf  (b_carry),
      .f_gt (a_gt),
      .f_ge (a_ge),
      .f_lt (a_lt),
      .f_le (a_le),
      .f_eq (a_eq)
   );

   assign inc_ovf = b_carry;

   always_comb begin
      // R1: carry fires only for an all-ones operand
      a_r1_overflow_point: assert (inc_ovf == (b_val == ALL_ONES))
         else $error("overflow flag at wrong operand value");
      // R2: overflow silences every relation flag
      if (inc_ovf) begin
         a_r2_flags_quiet: assert ({a_gt, a_ge, a_lt, a_le, a_eq} == 5'b0)
            else $error("relation flag active during overflow");
      end else begin
         // R7: port-level exclusivity
         a_r7_port_one_hot: assert ($countones({a_gt, a_eq, a_lt}) == 1)
            else $error("gt/eq/lt not exclusive");
      end
   end

endmodule

// File: tb/test_succ_cmp.sv
module test_succ_cmp;

   localparam int W = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0] a_val, b_val;
   logic d_gt, d_ge, d_lt, d_le, d_eq, d_ovf;
   logic c_gt, c_ge, c_lt, c_le, c_eq, c_ovf;

   succ_cmp #(.WIDTH(W), .CMP_ARCH(0)) i_succ_cmp (
      .a_val(a_val), .b_val(b_val),
      .a_gt(d_gt), .a_ge(d_ge), .a_lt(d_lt), .a_le(d_le), .a_eq(d_eq),
      .inc_ovf(d_ovf)
   );

   succ_cmp #(.WIDTH(W), .CMP_ARCH(1)) i_succ_cmp_chain (
      .a_val(a_val), .b_val(b_val),
      .a_gt(c_gt), .a_ge(c_ge), .a_lt(c_lt), .a_le(c_le), .a_eq(c_eq),
      .inc_ovf(c_ovf)
   );

   // expected flags packed as {gt, ge, lt, le, eq, ovf}
   typedef struct packed {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [5:0]   flags;
   } item_t;

   item_t exp_q[$];
   int    vectors     = 0;
   int    miscompares = 0;
   bit    done        = 1'b0;

   function automatic logic [5:0] model(input int a, input int b);
      int s;
      s = b + 1;
      if (s > (1 << W) - 1) return 6'b000001;
      return {a > s, a >= s, a < s, a <= s, a == s, 1'b0};
   endfunction

   task automatic apply(input int a, input int b);
      item_t it;
      @(posedge clk);
      #1;
      a_val = W'(a);
      b_val = W'(b);
      it.a = W'(a);
      it.b = W'(b);
      it.flags = model(a, b);
      exp_q.push_back(it);
   endtask

   task automatic fail_line(input string req, input item_t it,
                            input logic [5:0] act, input logic [5:0] exp);
      miscompares++;
      $display("FAIL %s a=%0d b=%0d actual=%b expected=%b (gt ge lt le eq ovf)",
               req, it.a, it.b, act, exp);
   endtask

   // monitor: compares on the falling edge, away from input changes
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            item_t it;
            logic [5:0] act, alt, e;
            it  = exp_q.pop_front();
            act = {d_gt, d_ge, d_lt, d_le, d_eq, d_ovf};
            alt = {c_gt, c_ge, c_lt, c_le, c_eq, c_ovf};
            e   = it.flags;
            vectors++;
            if (act[0] !== e[0])
               fail_line("R1 overflow", it, act, e);
            else if (e[0] && act[5:1] !== 5'b0)
               fail_line("R2 flags quiet", it, act, e);
            else if (act[1] !== e[1])
               fail_line("R3 equal", it, act, e);
            else if (act[5] !== e[5])
               fail_line("R4 greater", it, act, e);
            else if (act[3] !== e[3])
               fail_line("R5 less", it, act, e);
            else if (act[4] !== e[4] || act[2] !== e[2])
               fail_line("R6 inclusive", it, act, e);
            else if (!e[0] && ($countones({act[5], act[3], act[1]}) != 1))
               fail_line("R7 exclusive", it, act, e);
            else if (it.a == 9 && it.b == 5 && act !== 6'b110000)
               fail_line("R8 example", it, act, 6'b110000);
            else if (alt !== act)
               fail_line("R9 chain variant", it, alt, act);
         end
      end
   end

   initial begin
      a_val = '0;
      b_val = '0;
      // R10: zero inputs give A<B+1 in the same time step
      #2;
      vectors++;
      if ({d_gt, d_ge, d_lt, d_le, d_eq, d_ovf} !== 6'b001100) begin
         miscompares++;
         $display("FAIL R10 idle actual=%b expected=001100",
                  {d_gt, d_ge, d_lt, d_le, d_eq, d_ovf});
      end
      // R8 directed example
      apply(9, 5);
      // R2 / R1 boundary: B all ones and just below
      apply(0, 15);
      apply(15, 15);
      apply(15, 14);
      apply(14, 14);
      // R3 / R4 / R5 around the equal point
      apply(6, 5);
      apply(5, 5);
      apply(7, 5);
      // exhaustive sweep for R1..R7 and R9
      for (int b = 0; b < (1 << W); b++)
         for (int a = 0; a < (1 << W); a++)
            apply(a, b);
      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule